// File: doc/BRIEF.md
# Jump-Aware Writeback Enable Control

This block follows instructions through a four-stage in-order pipeline (fetch, decode, execute, writeback) and generates the register-file write enable, write register select and write data when each instruction reaches writeback. Every cycle in which the block can accept work, an upstream decoder presents one instruction tag. The tag carries a valid bit, a writes-register flag, a jump flag, a multicycle flag, a destination index and a result value.

A jump is resolved in the execute stage. The instruction fetched right after the jump is a delay slot and commits normally. The fetch slot after that is squashed before it can reach writeback. A multicycle instruction stays in execute for a fixed number of cycles and holds the younger stages back while it does. Writeback sees bubbles during that time, and the instruction writes once, in the cycle after its last execute cycle. A 16-entry register file with two combinational read ports is included so that committed state can be observed.

Top module: `wbj_top`

## Requirements
- R1: A synchronous active-high reset empties every pipeline stage and zeroes all registers. During the cycle after reset, wb_we is 0 and in_ready is 1. An instruction that was in flight when reset was sampled never commits.
- R2: An instruction is accepted at the clock edge where in_valid and in_ready are both 1. If it commits, wb_we is 1 with its wb_sel and wb_data during the cycle after the third following edge. The value can be read on a read port after the fourth following edge.
- R3: An instruction with in_jmp=1 never raises wb_we, even when in_wr=1. in_mc is ignored on a jump.
- R4: The instruction in the fetch slot directly after a jump (the delay slot) commits normally.
- R5: The fetch slot two slots after an uncancelled jump is squashed and never commits, whatever it holds. A bubble (in_valid=0) in that slot uses up the squash, so the next real instruction commits. A squashed jump has no effect.
- R6: An instruction with in_mc=1 stays in execute for MC_LAT cycles. in_ready is 0 for the first MC_LAT-1 of those cycles, and the younger stages hold their contents. wb_we stays 0 while it stalls, and the instruction writes exactly once.
- R7: Writes to register 0 are still signalled on wb_we and wb_sel=0, but register 0 always reads as 0.
- R8: Each of the two read ports returns, combinationally, the current contents of the register it selects.
- R9: Committed instructions appear on the write port in program order, and each appears exactly once.
- R10: An instruction with in_wr=0 never raises wb_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present in this fetch slot |
| in_wr | input | 1 | Instruction writes a register |
| in_jmp | input | 1 | Instruction is a jump |
| in_mc | input | 1 | Instruction is multicycle |
| in_dst | input | 4 | Destination register index |
| in_data | input | 32 | Result value to be written |
| in_ready | output | 1 | Fetch slot is accepted at the next edge |
| wb_we | output | 1 | Register-file write enable at writeback |
| wb_sel | output | 4 | Register-file write select |
| wb_data | output | 32 | Register-file write data |
| rd_sel_a | input | 4 | Read port A select |
| rd_data_a | output | 32 | Read port A data |
| rd_sel_b | input | 4 | Read port B select |
| rd_data_b | output | 32 | Read port B data |

## Verification
The bench overrides the multicycle latency to MC_LAT=4 and keeps 16 registers of 32 bits. With that latency the stall window lasts three cycles, one longer than the two delay slots after a jump. This makes it possible to test a multicycle instruction placed in a delay slot, a jump followed by a bubble, and back-to-back jumps, and to tell each of them apart from the plain squash pattern. A mixed stream with random flags then exercises stalls and squashes that overlap, against a slot-based model of which instructions commit.

// File: rtl/wbj_pkg.sv
package wbj_pkg;

    localparam int WBJ_DATA_W   = 32;
    localparam int WBJ_NUM_REGS = 16;
    localparam int WBJ_IDX_W    = $clog2(WBJ_NUM_REGS);

    typedef struct packed {
        logic                  valid;
        logic                  wr;
        logic                  jmp;
        logic                  mc;
        logic [WBJ_IDX_W-1:0]  dst;
        logic [WBJ_DATA_W-1:0] data;
    } wbj_tag_t;

    function automatic wbj_tag_t wbj_bubble();
        wbj_tag_t t;
        t = '0;
        return t;
    endfunction

    function automatic logic wbj_is_jump(input wbj_tag_t t);
        return t.valid & t.jmp;
    endfunction

    function automatic logic wbj_is_multi(input wbj_tag_t t);
        return t.valid & t.mc & ~t.jmp;
    endfunction

    function automatic logic wbj_commits(input wbj_tag_t t);
        return t.valid & t.wr & ~t.jmp;
    endfunction

endpackage

// File: rtl/wbj_front.sv
module wbj_front
    import wbj_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hold,
    input  logic     kill,
    input  wbj_tag_t fetch_in,
    output wbj_tag_t f_q,
    output wbj_tag_t d_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= wbj_bubble();
            d_q <= wbj_bubble();
        end else if (!hold) begin
            f_q <= fetch_in;
            d_q <= f_q;
            if (kill) begin
                d_q.valid <= 1'b0;
            end
        end
    end

    AST_FRONT_HOLD: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(f_q) && $stable(d_q))) else $error("front moved while held"); // R6

endmodule

// File: rtl/wbj_back.sv
module wbj_back
    import wbj_pkg::*;
#(
    parameter int MC_LAT = 3
)(
    input  logic     clk,
    input  logic     rst,
    input  wbj_tag_t d_in,
    output wbj_tag_t e_q,
    output wbj_tag_t w_q,
    output logic     stall
);

    localparam int CNT_W = (MC_LAT > 2) ? $clog2(MC_LAT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MC_LAT - 1);

    logic [CNT_W-1:0] cnt;

    always_comb begin
        stall = wbj_is_multi(e_q) && (cnt != LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e_q <= wbj_bubble();
            w_q <= wbj_bubble();
            cnt <= '0;
        end else if (stall) begin
            cnt <= cnt + 1'b1;
            w_q <= wbj_bubble();
        end else begin
            cnt <= '0;
            e_q <= d_in;
            w_q <= e_q;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST) else $error("multicycle counter overran"); // R6

    AST_MC_SINGLE_EXIT: assert property (@(posedge clk) disable iff (rst)
        (stall && cnt == LAST - 1'b1) |=> !stall) else $error("stall too long"); // R6

endmodule

// File: rtl/wbj_regfile.sv
module wbj_regfile
    import wbj_pkg::*;
#(
    parameter int N_RD = 2
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [WBJ_IDX_W-1:0]  wsel,
    input  logic [WBJ_DATA_W-1:0] wdata,
    input  logic [WBJ_IDX_W-1:0]  rsel  [N_RD],
    output logic [WBJ_DATA_W-1:0] rdata [N_RD]
);

    logic [WBJ_DATA_W-1:0] regs [WBJ_NUM_REGS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < WBJ_NUM_REGS; i++) begin
            if (rst || i == 0) begin
                regs[i] <= '0;
            end else if (we && wsel == WBJ_IDX_W'(i)) begin
                regs[i] <= wdata;
            end
        end
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        always_comb begin
            rdata[p] = regs[rsel[p]];
            if (!rst && rsel[p] == '0) begin
                AST_R0_ZERO: assert (rdata[p] == '0) else $error("register 0 nonzero"); // R7
            end
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && wsel != '0) |=> regs[$past(wsel)] == $past(wdata)) else $error("write lost"); // R2

endmodule

// File: rtl/wbj_top.sv
module wbj_top
    import wbj_pkg::*;
#(
    parameter int MC_LAT = 3
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic                  in_wr,
    input  logic                  in_jmp,
    input  logic                  in_mc,
    input  logic [WBJ_IDX_W-1:0]  in_dst,
    input  logic [WBJ_DATA_W-1:0] in_data,
    output logic                  in_ready,
    output logic                  wb_we,
    output logic [WBJ_IDX_W-1:0]  wb_sel,
    output logic [WBJ_DATA_W-1:0] wb_data,
    input  logic [WBJ_IDX_W-1:0]  rd_sel_a,
    output logic [WBJ_DATA_W-1:0] rd_data_a,
    input  logic [WBJ_IDX_W-1:0]  rd_sel_b,
    output logic [WBJ_DATA_W-1:0] rd_data_b
);

    wbj_tag_t fetch_in, f_q, d_q, e_q, w_q;
    logic     stall, kill;
    logic [WBJ_IDX_W-1:0]  rsel  [2];
    logic [WBJ_DATA_W-1:0] rdata [2];

    always_comb begin
        fetch_in.valid = in_valid;
        fetch_in.wr    = in_wr;
        fetch_in.jmp   = in_jmp;
        fetch_in.mc    = in_mc;
        fetch_in.dst   = in_dst;
        fetch_in.data  = in_data;
        kill           = wbj_is_jump(e_q);
        in_ready       = !stall;
        wb_we          = wbj_commits(w_q);
        wb_sel         = w_q.dst;
        wb_data        = w_q.data;
        rsel[0]        = rd_sel_a;
        rsel[1]        = rd_sel_b;
        rd_data_a      = rdata[0];
        rd_data_b      = rdata[1];
    end

    wbj_front u_front (
        .clk      (clk),
        .rst      (rst),
        .hold     (stall),
        .kill     (kill),
        .fetch_in (fetch_in),
        .f_q      (f_q),
        .d_q      (d_q)
    );

    wbj_back #(.MC_LAT(MC_LAT)) u_back (
        .clk   (clk),
        .rst   (rst),
        .d_in  (d_q),
        .e_q   (e_q),
        .w_q   (w_q),
        .stall (stall)
    );

    wbj_regfile #(.N_RD(2)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (wb_we),
        .wsel  (wb_sel),
        .wdata (wb_data),
        .rsel  (rsel),
        .rdata (rdata)
    );

    AST_SQUASH_SECOND: assert property (@(posedge clk) disable iff (rst)
        wbj_is_jump(e_q) |=> !d_q.valid) else $error("second slot not squashed"); // R5

    AST_JUMP_SILENT: assert property (@(posedge clk) disable iff (rst)
        wbj_is_jump(e_q) |=> !wb_we) else $error("jump wrote back"); // R3

    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        stall |=> !wb_we) else $error("write during stall"); // R6

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wb_we && in_ready)) else $error("activity after reset"); // R1

endmodule

// File: tb/wbj_top_tb.sv
module wbj_top_tb;
    import wbj_pkg::*;

    localparam int LAT = 4;

    typedef struct {
        logic [WBJ_IDX_W-1:0]  dst;
        logic [WBJ_DATA_W-1:0] data;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_wr = 1'b0, in_jmp = 1'b0, in_mc = 1'b0;
    logic [WBJ_IDX_W-1:0]  in_dst = '0;
    logic [WBJ_DATA_W-1:0] in_data = '0;
    logic in_ready, wb_we;
    logic [WBJ_IDX_W-1:0]  wb_sel;
    logic [WBJ_DATA_W-1:0] wb_data;
    logic [WBJ_IDX_W-1:0]  rd_sel_a = '0, rd_sel_b = '0;
    logic [WBJ_DATA_W-1:0] rd_data_a, rd_data_b;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    exp_t exp_q[$];
    logic [WBJ_DATA_W-1:0] shadow [WBJ_NUM_REGS];
    logic [1:0] kmask = 2'b00;
    logic last_we;
    logic [WBJ_DATA_W-1:0] last_rd;
    logic [31:0] lfsr = 32'h1ACE_5EED;

    wbj_top #(.MC_LAT(LAT)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_wr(in_wr), .in_jmp(in_jmp),
        .in_mc(in_mc), .in_dst(in_dst), .in_data(in_data), .in_ready(in_ready),
        .wb_we(wb_we), .wb_sel(wb_sel), .wb_data(wb_data),
        .rd_sel_a(rd_sel_a), .rd_data_a(rd_data_a), .rd_sel_b(rd_sel_b), .rd_data_b(rd_data_b)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // driver: one fetch slot, returns the number of stalled cycles
    task automatic send(input logic v, input logic wr, input logic jmp, input logic mc,
                        input logic [WBJ_IDX_W-1:0] dst, input logic [WBJ_DATA_W-1:0] data,
                        output int waits);
        logic killed;
        @(negedge clk);
        last_we = wb_we;
        last_rd = rd_data_a;
        in_valid = v; in_wr = wr; in_jmp = jmp; in_mc = mc; in_dst = dst; in_data = data;
        waits = 0;
        while (!in_ready) begin
            @(negedge clk);
            waits++;
        end
        @(posedge clk);
        killed = kmask[0];
        kmask = kmask >> 1;
        if (v && !killed) begin
            if (jmp) begin
                kmask = kmask | 2'b10;
            end else if (wr) begin
                exp_q.push_back('{dst: dst, data: data});
                if (dst != '0) shadow[dst] = data;
            end
        end
    endtask

    task automatic put(input logic wr, input logic jmp, input logic mc,
                       input logic [WBJ_IDX_W-1:0] dst, input logic [WBJ_DATA_W-1:0] data);
        int w;
        send(1'b1, wr, jmp, mc, dst, data, w);
    endtask

    task automatic idle(input int n);
        int w;
        for (int i = 0; i < n; i++) send(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, w);
    endtask

    task automatic chk_reg(input string req, input int r);
        @(negedge clk);
        rd_sel_a = WBJ_IDX_W'(r);
        rd_sel_b = WBJ_IDX_W'(r);
        #1;
        check(req, rd_data_a, (r == 0) ? '0 : shadow[r]);
        check(req, rd_data_b, (r == 0) ? '0 : shadow[r]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        exp_q.delete();
        kmask = 2'b00;
        for (int i = 0; i < WBJ_NUM_REGS; i++) shadow[i] = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && wb_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected commit sel %h data %h expected none", wb_sel, wb_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (wb_sel !== e.dst || wb_data !== e.data) begin
                    errors++;
                    $display("FAIL R9 commit actual %h/%h expected %h/%h", wb_sel, wb_data, e.dst, e.data);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual %0d expected below 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [4:0] wl;
        int w;
        for (int i = 0; i < WBJ_NUM_REGS; i++) shadow[i] = '0;
        do_reset();

        // R1: reset state
        @(negedge clk);
        rd_sel_a = 4'd3; rd_sel_b = 4'd0; #1;
        check("R1 we", wb_we, 0);
        check("R1 ready", in_ready, 1);
        check("R1 rd_a", rd_data_a, 0);
        check("R1 rd_b", rd_data_b, 0);

        // R2: latency of a single instruction
        rd_sel_a = 4'd3;
        put(1, 0, 0, 4'd3, 32'hA5A5_0003);
        for (int i = 0; i < 5; i++) begin
            idle(1);
            wl[i] = last_we;
            if (i == 3) check("R2 rd before commit", last_rd, 0);
            if (i == 4) check("R2 rd after commit", last_rd, 32'hA5A5_0003);
        end
        check("R2 we timing", wl, 5'b01000);

        // R10: no write flag
        put(0, 0, 0, 4'd4, 32'hDEAD_0004);
        idle(5);
        chk_reg("R10", 4);

        // R3 R4 R5: jump pattern
        put(1, 1, 0, 4'd6, 32'h0000_0666);
        put(1, 0, 0, 4'd7, 32'h0000_0777);
        put(1, 0, 0, 4'd8, 32'h0000_0888);
        put(1, 0, 0, 4'd9, 32'h0000_0999);
        for (int i = 0; i < 4; i++) begin
            idle(1);
            wl[i] = last_we;
        end
        check("R3 R4 R5 we pattern", wl[3:0], 4'b1010);
        idle(3);
        chk_reg("R3", 6);
        chk_reg("R4", 7);
        chk_reg("R5", 8);
        chk_reg("R5", 9);

        // R5: bubble uses up the squash
        put(0, 1, 0, 4'd1, 32'h1);
        put(1, 0, 0, 4'd10, 32'h0000_0A0A);
        idle(1);
        put(1, 0, 0, 4'd11, 32'h0000_0B0B);
        idle(6);
        chk_reg("R5 bubble", 11);

        // R5: back-to-back jumps, squashed jump
        put(1, 1, 0, 4'd1, 32'h1);
        put(1, 1, 0, 4'd1, 32'h2);
        put(1, 0, 0, 4'd12, 32'h0000_0C0C);
        put(1, 0, 0, 4'd13, 32'h0000_0D0D);
        put(1, 0, 0, 4'd14, 32'h0000_0E0E);
        idle(6);
        chk_reg("R5 jj", 12);
        chk_reg("R5 jj", 13);
        chk_reg("R5 jj", 14);

        // R6: multicycle stall length
        put(1, 0, 1, 4'd5, 32'h0000_5555);
        put(1, 0, 0, 4'd2, 32'h0000_2222);
        put(1, 0, 0, 4'd15, 32'h0000_FFFF);
        send(1, 1, 0, 0, 4'd1, 32'h0000_1111, w);
        check("R6 stall cycles", w, LAT - 1);
        idle(9);
        chk_reg("R6", 5);
        chk_reg("R6", 1);

        // R6 R5: multicycle in a delay slot
        put(1, 1, 0, 4'd1, 32'h3);
        put(1, 0, 1, 4'd3, 32'h0000_3333);
        put(1, 0, 0, 4'd3, 32'h0000_BAD3);
        put(1, 0, 0, 4'd2, 32'h0000_2020);
        idle(10);
        chk_reg("R6 slot", 3);
        chk_reg("R6 slot", 2);

        // R7: register 0
        put(1, 0, 0, 4'd0, 32'hFFFF_FFFF);
        idle(6);
        chk_reg("R7", 0);

        // R9: mixed stream
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            send(lfsr[3:0] != 4'd0, lfsr[4] | lfsr[5], lfsr[8:6] == 3'd0,
                 lfsr[11:9] == 3'd0, lfsr[15:12], {lfsr[15:0], n[15:0]}, w);
        end
        idle(12);
        check("R9 drained", exp_q.size(), 0);
        for (int r = 0; r < WBJ_NUM_REGS; r++) chk_reg("R8", r);

        // R1: reset with work in flight
        put(1, 0, 0, 4'd5, 32'h0BAD_0005);
        put(1, 0, 0, 4'd6, 32'h0BAD_0006);
        do_reset();
        @(negedge clk);
        check("R1 we after reset", wb_we, 0);
        check("R1 ready after reset", in_ready, 1);
        idle(6);
        chk_reg("R1 in flight", 5);
        chk_reg("R1 in flight", 6);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule